// File: doc/BRIEF.md
# Debug Register Bus Target

This block sits on a single-clock debug register bus and answers a master that uses a four-phase level handshake. The master raises a request, and in that same cycle it presents a 4-bit register address, a write-enable and 64-bit write data. The target takes all three on the first clock edge where the request is high and acknowledge is low. On that edge it either updates the selected register or loads the register's contents into a held read-data output.

Acknowledge rises one clock later. It stays high for as long as the master keeps the request high, and it falls one clock after the request drops. The master then leaves the request low for at least one clock before it starts another transfer. Because the target takes in a request only while acknowledge is low, a request held high across many cycles is serviced once.

The bank has `NUM_REGS` implemented registers. The remaining addresses read as zero and ignore writes, and transfers to them complete the handshake normally.

Top module: `dbg_reg_target`

## Requirements
- R1: After synchronous reset, acknowledge is low, read data is zero and every register reads back as zero.
- R2: When the request is high while acknowledge is low at a clock edge, acknowledge is high after that edge. This is exactly one clock after the request is first seen.
- R3: Acknowledge stays high while the request stays high. It goes low one clock after the request is low at a clock edge.
- R4: A write (write-enable = 1) stores the write data in the register selected by the address. No other register changes.
- R5: A write takes effect once per handshake. Write data, address or write-enable that change while the request is held high after capture have no effect.
- R6: A read (write-enable = 0) places the selected register's value on the read-data output by the cycle in which acknowledge is high. That value stays stable for as long as acknowledge is high.
- R7: With the default parameters, addresses 10 to 15 are unimplemented. Reads from them return zero and writes to them change nothing. Both complete the handshake as usual.
- R8: Read data keeps its last read value after the handshake ends, and it is not altered by write transfers, until the next read is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Transfer request from the master, level |
| we | input | 1 | 1 = write, 0 = read; valid when req rises |
| addr | input | ADDR_W (4) | Register select; valid when req rises |
| wdata | input | DATA_W (64) | Write data; valid when req rises |
| rdata | output | DATA_W (64) | Held read data |
| ack | output | 1 | Acknowledge; high until req falls |

## Verification
Seeded random transfers mix reads and writes across all 16 addresses with random data. Each transfer holds the request for a random number of extra cycles, and during that hold the bench scrambles the address, write data and write-enable. This separates a target that captures once from one that re-captures or follows live inputs. Directed cases cover the reset state, the highest implemented register, writes and reads to unimplemented addresses, and back-to-back transfers that use only the minimum gap. Read data is also checked during the gap and after writes, which shows that it is held.

// File: rtl/dbg_tgt_pkg.sv
package dbg_tgt_pkg;
   typedef enum logic {
      HS_IDLE = 1'b0,
      HS_ACK  = 1'b1
   } hs_state_e;
endpackage

// File: rtl/dbg_hs_ctrl.sv
module dbg_hs_ctrl
   import dbg_tgt_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic req,
   output logic ack,
   output logic capture
);
   hs_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         HS_IDLE: if (req)  state_d = HS_ACK;
         HS_ACK:  if (!req) state_d = HS_IDLE;
         default:           state_d = HS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= HS_IDLE;
      else     state_q <= state_d;
   end

   assign ack     = (state_q == HS_ACK);
   assign capture = (state_q == HS_IDLE) && req;

   // R2
   ack_rise_chk: assert property (@(posedge clk) disable iff (rst)
      (req && !ack) |=> ack);
   // R3
   ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (req && ack) |=> ack);
   // R3
   ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (!req && ack) |=> !ack);
   // R5
   capture_once_chk: assert property (@(posedge clk) disable iff (rst)
      capture |=> !capture);
endmodule

// File: rtl/dbg_reg_bank.sv
module dbg_reg_bank #(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 64,
   parameter int NUM_REGS = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_word
);
   logic [DATA_W-1:0] regs_q [NUM_REGS];
   logic [NUM_REGS-1:0] wr_en;

   for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      assign wr_en[gi] = wr_stb && (addr == ADDR_W'(gi));
      always_ff @(posedge clk) begin
         if (rst)            regs_q[gi] <= '0;
         else if (wr_en[gi]) regs_q[gi] <= wdata;
      end
   end

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (addr == ADDR_W'(i)) rd_word = regs_q[i];
      end
   end

   // R4
   wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(wr_en));
   // R7
   wr_unimpl_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_stb && (int'(addr) >= NUM_REGS)) |-> (wr_en == '0));
endmodule

// File: rtl/dbg_rd_hold.sv
module dbg_rd_hold #(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   always_ff @(posedge clk) begin
      if (rst)       dout <= '0;
      else if (load) dout <= din;
   end

   // R8
   rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(dout));
endmodule

// File: rtl/dbg_reg_target.sv
module dbg_reg_target #(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 64,
   parameter int NUM_REGS = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              ack
);
   localparam int ADDR_SPACE = 1 << ADDR_W;

   if (NUM_REGS < 1 || NUM_REGS > ADDR_SPACE) begin : g_bad_regs
      $error("NUM_REGS must be between 1 and 2**ADDR_W");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   logic              capture;
   logic [DATA_W-1:0] rd_word;

   dbg_hs_ctrl u_hs (
      .clk     (clk),
      .rst     (rst),
      .req     (req),
      .ack     (ack),
      .capture (capture)
   );

   dbg_reg_bank #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS)
   ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_stb  (capture && we),
      .addr    (addr),
      .wdata   (wdata),
      .rd_word (rd_word)
   );

   dbg_rd_hold #(
      .DATA_W (DATA_W)
   ) u_hold (
      .clk  (clk),
      .rst  (rst),
      .load (capture && !we),
      .din  (rd_word),
      .dout (rdata)
   );

   // R6
   rdata_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (ack && req) |=> $stable(rdata));
   // R1
   reset_ack_chk: assert property (@(posedge clk)
      rst |=> (!ack && rdata == '0));
endmodule

// File: tb/dbg_reg_target_tb.sv
module dbg_reg_target_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 4;
   localparam int DW = 64;
   localparam int NREG = 10;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req = 1'b0;
   logic          we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          ack;

   int checks = 0;
   int failures = 0;
   bit finished = 0;
   logic [DW-1:0] model [16];
   logic [DW-1:0] last_rd = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbg_reg_target #(.ADDR_W(AW), .DATA_W(DW), .NUM_REGS(NREG)) u_dut (
      .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr),
      .wdata(wdata), .rdata(rdata), .ack(ack)
   );

   function automatic logic [DW-1:0] rand64();
      return {$urandom, $urandom};
   endfunction

   function automatic logic [DW-1:0] expect_read(input logic [AW-1:0] a);
      return (int'(a) < NREG) ? model[a] : '0;
   endfunction

   task automatic check(input bit ok, input string tag,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // one complete handshake, hold = extra cycles with req high
   task automatic xfer(input bit w, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input int hold);
      logic [DW-1:0] exp;
      req = 1'b1; we = w; addr = a; wdata = d;
      check(ack == 1'b0, "R2 ack low before capture", 64'(ack), 0);
      step();
      check(ack == 1'b1, "R2 ack one clock after req", 64'(ack), 1);
      if (w) begin
         if (int'(a) < NREG) model[a] = d;
         exp = last_rd;
         check(rdata == exp, "R8 rdata unchanged by write", rdata, exp);
      end else begin
         exp = expect_read(a);
         last_rd = exp;
         check(rdata == exp,
               (int'(a) < NREG) ? "R6 read data" : "R7 unimpl reads zero",
               rdata, exp);
      end
      for (int h = 0; h < hold; h++) begin
         addr = AW'($urandom); wdata = rand64(); we = $urandom_range(0, 1) != 0;
         step();
         check(ack == 1'b1, "R3 ack held while req high", 64'(ack), 1);
         check(rdata == exp, "R6 rdata stable during ack", rdata, exp);
      end
      req = 1'b0; we = $urandom_range(0, 1) != 0; wdata = rand64();
      step();
      check(ack == 1'b0, "R3 ack drops after req falls", 64'(ack), 0);
      step();
      check(rdata == last_rd, "R8 rdata held after handshake", rdata, last_rd);
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 100000 && !finished) begin
         @(posedge clk);
         cyc++;
      end
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=done", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240917));
      for (int i = 0; i < 16; i++) model[i] = '0;
      step(); step();
      rst = 1'b0;
      step();
      check(ack == 1'b0, "R1 ack low after reset", 64'(ack), 0);
      check(rdata == '0, "R1 rdata zero after reset", rdata, 0);
      for (int i = 0; i < 16; i++) xfer(1'b0, AW'(i), '0, 0);
      // directed: top implemented register, all-ones
      xfer(1'b1, AW'(NREG-1), '1, 2);
      xfer(1'b0, AW'(NREG-1), '0, 1);
      // R7 write to unimplemented address ignored
      xfer(1'b1, 4'd12, 64'hDEAD_BEEF_0123_4567, 0);
      xfer(1'b0, 4'd12, '0, 0);
      // R4 neighbours untouched, R5 long hold with scrambled inputs
      xfer(1'b1, 4'd3, 64'h1111_2222_3333_4444, 5);
      xfer(1'b0, 4'd2, '0, 0);
      xfer(1'b0, 4'd3, '0, 3);
      xfer(1'b0, 4'd4, '0, 0);
      // random mix
      for (int n = 0; n < 300; n++) begin
         xfer($urandom_range(0, 1) != 0, AW'($urandom), rand64(),
              $urandom_range(0, 3));
      end
      // final sweep: every register against the model (R4, R5)
      for (int i = 0; i < 16; i++) xfer(1'b0, AW'(i), '0, 0);
      // R1 reset again clears everything
      rst = 1'b1; step(); rst = 1'b0;
      for (int i = 0; i < 16; i++) model[i] = '0;
      last_rd = '0;
      step();
      check(rdata == '0, "R1 rdata zero after second reset", rdata, 0);
      xfer(1'b0, 4'd3, '0, 0);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule